// File: doc/BRIEF.md
# Nine-Level Staircase PWM Gate Controller

This block produces the nine gate commands for a single-phase switched-capacitor inverter. The inverter has two capacitor cells, with five cell switches named S11, S12, S21, S22 and S23, and an output H-bridge of four switches named T1 to T4. A held sinusoidal reference is compared with eight triangular carriers that are stacked in adjacent bands. The number of carriers lying below the reference selects one of nine output levels, from -4 to +4 input-voltage units. Each level has its own switch pattern. In the cell patterns, the capacitors alternate between parallel charging and series discharge.

The carriers share one up/down counter. Each carrier adds its band offset to that counter and, depending on the disposition mode, may use the mirrored slope. The reference is a parabolic half-wave approximation of a sine. Its amplitude word is the modulation index in 1/16 steps, and the value is refreshed at a fixed interval derived from the carrier-to-reference frequency ratio. The level register is a state machine with these states: IDLE, N4, N3, N2, N1, Z, P1, P2, P3 and P4. The transitions are as follows. IDLE goes to a level state when enable is high. Any state goes to IDLE when enable is low. A level state goes to the state that matches the current band count; two bands in one step are allowed. A dead-time stage delays every newly raised switch command before it reaches the gates.

Top module: `ninelevel_pwm_ctrl`

## Requirements
- R1: While `rst` is high, `gate_o` is all zero, and after reset `level_o` reads 0.
- R2: While `en` is low, `gate_o` is all zero in the same cycle. From the first clock edge with `en` low, `level_o` reads 0 (state IDLE).
- R3: The carrier counter runs 0 up to CAR_STEPS-1 and back down. Carrier k (k = 0 to 7) is k*CAR_STEPS plus the counter, or plus its mirror (CAR_STEPS-1 minus the counter). With n the number of carriers strictly below the reference, `level_o` is n-4. It is a 4-bit two's-complement code that always lies in -4 to +4.
- R4: `gate_o` bit order is 0 S11, 1 S12, 2 S21, 3 S22, 4 S23, 5 T1, 6 T2, 7 T3, 8 T4. The cell switches are set by the level magnitude: 4 gives S11+S21+S23, 3 gives S12+S21+S23, 2 gives S11+S22, 1 and 0 give S12+S22. The bridge gives T1+T4 for positive levels, T2+T3 for negative levels and T1+T3 for zero.
- R5: During a positive level T2 and T3 are off, and during a negative level T1 and T4 are off.
- R6: S11 and S12 are never on together. S22 is never on together with S21 or S23. T1 is never on with T2, and T3 is never on with T4.
- R7: A switch command that rises reaches its gate DEAD_CYC cycles later, provided it stays high throughout. A command that falls removes the gate in the same cycle.
- R8: The modulation index is `amp_i`/16 and is clamped at 4. Over a full reference period, 58 (about 3.6) produces all nine levels, 42 (about 2.6) produces exactly -3 to +3, and 0 produces only level 0.
- R9: `mode_i` selects the carrier arrangement: 0 keeps all carriers in phase, 1 mirrors the four carriers above zero, 2 mirrors every odd carrier, and 3 behaves as 0. At index 3.6, modes 1 and 2 also produce all nine levels over a reference period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; gates are off when low |
| amp_i | input | AMP_W | Modulation index, 4 fractional bits |
| mode_i | input | 2 | Carrier disposition select |
| gate_o | output | 9 | Switch gate commands, bit order as in R4 |
| level_o | output | 4 | Current output level, two's complement |

## Verification
The bench uses a small configuration and sweeps a full reference period at each of several index values. At 3.6 all nine levels must appear. At 2.6 the two outer levels must never appear, which separates band counting from a saturating count. At index zero the reference sits exactly on the middle band edge, so an off-by-one in the comparison would show up as stray +/-1 levels. At the clamped maximum the clamp is exercised. The two mirrored modes are run at 3.6 to show that the inverted carriers still cover every band. On every cycle the gates are compared with a model that derives the expected pattern from the reported level and applies the dead-time delay. Enable is dropped in the middle of a run so that both the forced-off path and the delayed restart are covered.

// File: rtl/nlpwm_pkg.sv
package nlpwm_pkg;

    localparam int NUM_SW  = 9;
    localparam int NUM_CAR = 8;

    typedef enum logic [1:0] {
        DISP_SAME   = 2'd0,
        DISP_SPLIT  = 2'd1,
        DISP_ALT    = 2'd2,
        DISP_SPARE  = 2'd3
    } disp_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_N4, ST_N3, ST_N2, ST_N1, ST_Z, ST_P1, ST_P2, ST_P3, ST_P4
    } lvl_st_e;

    // Cell switch sets (bits 0..4) and bridge sets (bits 5..8)
    localparam logic [8:0] CELL_M4  = 9'b0_0001_0101; // S11 S21 S23
    localparam logic [8:0] CELL_M3  = 9'b0_0001_0110; // S12 S21 S23
    localparam logic [8:0] CELL_M2  = 9'b0_0000_1001; // S11 S22
    localparam logic [8:0] CELL_M1  = 9'b0_0000_1010; // S12 S22
    localparam logic [8:0] BRG_POS  = 9'b1_0010_0000; // T1 T4
    localparam logic [8:0] BRG_NEG  = 9'b0_1100_0000; // T2 T3
    localparam logic [8:0] BRG_ZERO = 9'b0_1010_0000; // T1 T3

endpackage

// File: rtl/nlpwm_carrier.sv
module nlpwm_carrier #(
    parameter int STEPS = 1000
) (
    input  logic                     clk,
    input  logic                     rst,
    output logic [$clog2(STEPS)-1:0] cnt_o
);
    localparam int TW = $clog2(STEPS);

    logic rising_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o    <= '0;
            rising_q <= 1'b1;
        end else if (rising_q) begin
            if (cnt_o == TW'(STEPS - 1)) begin
                rising_q <= 1'b0;
                cnt_o    <= cnt_o - 1'b1;
            end else begin
                cnt_o    <= cnt_o + 1'b1;
            end
        end else begin
            if (cnt_o == '0) begin
                rising_q <= 1'b1;
                cnt_o    <= cnt_o + 1'b1;
            end else begin
                cnt_o    <= cnt_o - 1'b1;
            end
        end
    end
endmodule

// File: rtl/nlpwm_reference.sv
module nlpwm_reference #(
    parameter int STEPS = 1000,
    parameter int PTS   = 200,
    parameter int DIV   = 999,
    parameter int AMP_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [AMP_W-1:0]             amp_i,
    output logic [$clog2(8*STEPS+1)-1:0] refv_o
);
    localparam int RW   = $clog2(8*STEPS+1);
    localparam int HP   = PTS / 2;
    localparam int MID  = 4 * STEPS;
    localparam int PW   = $clog2(PTS + 1);
    localparam int DW   = $clog2(DIV + 1);

    logic [PW-1:0] ph_q;
    logic [DW-1:0] div_q;
    logic          neg_half;
    logic [31:0]   qpos, amp_full, amp_lim, shape, mag, nxt;

    always_comb begin
        neg_half = (32'(ph_q) >= 32'(HP));
        qpos     = neg_half ? 32'(ph_q) - 32'(HP) : 32'(ph_q);
        amp_full = (32'(amp_i) * 32'(STEPS)) >> 4;
        amp_lim  = (amp_full > 32'(MID)) ? 32'(MID) : amp_full;
        shape    = 32'd4 * qpos * (32'(HP) - qpos);
        mag      = (amp_lim * shape) / 32'(HP * HP);
        nxt      = neg_half ? 32'(MID) - mag : 32'(MID) + mag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q  <= '0;
            ph_q   <= '0;
            refv_o <= RW'(MID);
        end else if (div_q == DW'(DIV - 1)) begin
            div_q  <= '0;
            ph_q   <= (ph_q == PW'(PTS - 1)) ? '0 : ph_q + 1'b1;
            refv_o <= RW'(nxt);
        end else begin
            div_q  <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/nlpwm_band.sv
module nlpwm_band
    import nlpwm_pkg::*;
#(
    parameter int STEPS = 1000
) (
    input  logic [$clog2(8*STEPS+1)-1:0] refv_i,
    input  logic [$clog2(STEPS)-1:0]     cnt_i,
    input  disp_e                        mode_i,
    output logic [3:0]                   nhit_o
);
    logic [NUM_CAR-1:0] hit;

    for (genvar k = 0; k < NUM_CAR; k++) begin : g_car
        logic        mirror;
        logic [31:0] cval;
        always_comb begin
            unique case (mode_i)
                DISP_SPLIT: mirror = (k >= NUM_CAR / 2);
                DISP_ALT:   mirror = (k % 2 == 1);
                default:    mirror = 1'b0;
            endcase
            cval = 32'(k * STEPS) +
                   (mirror ? 32'(STEPS - 1) - 32'(cnt_i) : 32'(cnt_i));
        end
        assign hit[k] = (32'(refv_i) > cval);
    end

    assign nhit_o = 4'($countones(hit));
endmodule

// File: rtl/nlpwm_deadtime.sv
module nlpwm_deadtime #(
    parameter int N        = 9,
    parameter int DEAD_CYC = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cmd_i,
    output logic [N-1:0] gate_o
);
    localparam int CW = $clog2(DEAD_CYC + 2);

    for (genvar i = 0; i < N; i++) begin : g_sw
        logic [CW-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst || !cmd_i[i])
                cnt_q <= '0;
            else if (cnt_q != CW'(DEAD_CYC))
                cnt_q <= cnt_q + 1'b1;
        end
        assign gate_o[i] = cmd_i[i] && (cnt_q == CW'(DEAD_CYC));
    end
endmodule

// File: rtl/ninelevel_pwm_ctrl.sv
module ninelevel_pwm_ctrl
    import nlpwm_pkg::*;
#(
    parameter int CAR_STEPS   = 1000,
    parameter int CAR_PER_REF = 100,
    parameter int REF_PTS     = 200,
    parameter int DEAD_CYC    = 4,
    parameter int AMP_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [AMP_W-1:0] amp_i,
    input  logic [1:0]       mode_i,
    output logic [8:0]       gate_o,
    output logic [3:0]       level_o
);
    localparam int REF_DIV = (2 * (CAR_STEPS - 1) * CAR_PER_REF) / REF_PTS;
    localparam int RW      = $clog2(8 * CAR_STEPS + 1);
    localparam int TW      = $clog2(CAR_STEPS);

    logic [TW-1:0]     car_cnt;
    logic [RW-1:0]     refv;
    logic [3:0]        nhit;
    lvl_st_e           st_q, st_d;
    logic [NUM_SW-1:0] cmd, gate_dt;

    nlpwm_carrier #(.STEPS(CAR_STEPS)) u_carrier (
        .clk(clk), .rst(rst), .cnt_o(car_cnt)
    );

    nlpwm_reference #(
        .STEPS(CAR_STEPS), .PTS(REF_PTS), .DIV(REF_DIV), .AMP_W(AMP_W)
    ) u_reference (
        .clk(clk), .rst(rst), .amp_i(amp_i), .refv_o(refv)
    );

    nlpwm_band #(.STEPS(CAR_STEPS)) u_band (
        .refv_i(refv), .cnt_i(car_cnt), .mode_i(disp_e'(mode_i)), .nhit_o(nhit)
    );

    // Next state: band count picks the level, disable returns to IDLE
    always_comb begin
        if (!en) begin
            st_d = ST_IDLE;
        end else begin
            unique case (nhit)
                4'd0:    st_d = ST_N4;
                4'd1:    st_d = ST_N3;
                4'd2:    st_d = ST_N2;
                4'd3:    st_d = ST_N1;
                4'd5:    st_d = ST_P1;
                4'd6:    st_d = ST_P2;
                4'd7:    st_d = ST_P3;
                4'd8:    st_d = ST_P4;
                default: st_d = ST_Z;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // Outputs: switch commands and level code per state
    always_comb begin
        unique case (st_q)
            ST_P4:   begin cmd = CELL_M4 | BRG_POS;  level_o = 4'sd4;  end
            ST_P3:   begin cmd = CELL_M3 | BRG_POS;  level_o = 4'sd3;  end
            ST_P2:   begin cmd = CELL_M2 | BRG_POS;  level_o = 4'sd2;  end
            ST_P1:   begin cmd = CELL_M1 | BRG_POS;  level_o = 4'sd1;  end
            ST_Z:    begin cmd = CELL_M1 | BRG_ZERO; level_o = 4'sd0;  end
            ST_N1:   begin cmd = CELL_M1 | BRG_NEG;  level_o = 4'hF;   end
            ST_N2:   begin cmd = CELL_M2 | BRG_NEG;  level_o = 4'hE;   end
            ST_N3:   begin cmd = CELL_M3 | BRG_NEG;  level_o = 4'hD;   end
            ST_N4:   begin cmd = CELL_M4 | BRG_NEG;  level_o = 4'hC;   end
            default: begin cmd = '0;                 level_o = 4'd0;   end
        endcase
    end

    nlpwm_deadtime #(.N(NUM_SW), .DEAD_CYC(DEAD_CYC)) u_deadtime (
        .clk(clk), .rst(rst), .cmd_i(cmd), .gate_o(gate_dt)
    );

    assign gate_o = (en && !rst) ? gate_dt : '0;
endmodule

// File: rtl/ninelevel_pwm_ctrl_chk.sv
module ninelevel_pwm_ctrl_chk #(
    parameter int DEAD_CYC = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic [8:0] gate_o,
    input logic [3:0] level_o
);
    p_cell1_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(gate_o[0] && gate_o[1]));
    p_cell2_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(gate_o[3] && (gate_o[2] || gate_o[4])));
    p_bridge_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(gate_o[5] && gate_o[6]) && !(gate_o[7] && gate_o[8]));
    p_idle_level_r2: assert property (@(posedge clk) disable iff (rst)
        !en |=> (level_o == 4'd0));
    p_level_range_r3: assert property (@(posedge clk) disable iff (rst)
        ($signed(level_o) >= -4) && ($signed(level_o) <= 4));
    p_pos_bridge_r5: assert property (@(posedge clk) disable iff (rst)
        ($signed(level_o) > 0) |-> !(gate_o[6] || gate_o[7]));
    p_neg_bridge_r5: assert property (@(posedge clk) disable iff (rst)
        ($signed(level_o) < 0) |-> !(gate_o[5] || gate_o[8]));
    p_dead_s11_r7: assert property (@(posedge clk) disable iff (rst)
        (DEAD_CYC > 0 && $rose(gate_o[0])) |-> !$past(gate_o[1]));
    p_dead_s22_r7: assert property (@(posedge clk) disable iff (rst)
        (DEAD_CYC > 0 && $rose(gate_o[3])) |-> !($past(gate_o[2]) || $past(gate_o[4])));
    p_dead_t1_r7: assert property (@(posedge clk) disable iff (rst)
        (DEAD_CYC > 0 && $rose(gate_o[5])) |-> !$past(gate_o[6]));
    p_dead_t4_r7: assert property (@(posedge clk) disable iff (rst)
        (DEAD_CYC > 0 && $rose(gate_o[8])) |-> !$past(gate_o[7]));
endmodule

bind ninelevel_pwm_ctrl ninelevel_pwm_ctrl_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk(clk), .rst(rst), .en(en), .gate_o(gate_o), .level_o(level_o)
);

// File: tb/ninelevel_pwm_ctrl_bench.sv
`timescale 1ns/1ps
module ninelevel_pwm_ctrl_bench;
    localparam int H    = 16;
    localparam int CPR  = 8;
    localparam int PTS  = 48;
    localparam int DEAD = 3;
    localparam int RPER = PTS * ((2 * (H - 1) * CPR) / PTS);

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [7:0] amp = 8'd0;
    logic [1:0] mode = 2'd0;
    logic [8:0] gate;
    logic [3:0] lvl;

    int         n_chk = 0;
    int         n_err = 0;
    int         hold [9];
    logic [8:0] prev_pat = '0;
    logic [8:0] seen = '0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    ninelevel_pwm_ctrl #(
        .CAR_STEPS(H), .CAR_PER_REF(CPR), .REF_PTS(PTS), .DEAD_CYC(DEAD), .AMP_W(8)
    ) u_ninelevel_pwm_ctrl (
        .clk(clk), .rst(rst), .en(en), .amp_i(amp), .mode_i(mode),
        .gate_o(gate), .level_o(lvl)
    );

    // Expected switch set for a level, bit order as in R4
    function automatic logic [8:0] pattern(int L);
        logic [8:0] p;
        int m;
        m = (L < 0) ? -L : L;
        p = '0;
        if (m > 4) return '0;
        if (m == 4 || m == 2) p[0] = 1'b1; else p[1] = 1'b1;
        if (m >= 3) begin p[2] = 1'b1; p[4] = 1'b1; end else p[3] = 1'b1;
        if (L > 0)      begin p[5] = 1'b1; p[8] = 1'b1; end
        else if (L < 0) begin p[6] = 1'b1; p[7] = 1'b1; end
        else            begin p[5] = 1'b1; p[7] = 1'b1; end
        return p;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        logic [8:0] pat, expg;
        bit active;
        int L;
        @(negedge clk);
        active = en && !rst;
        L = $signed(lvl);
        pat = active ? pattern(L) : '0;
        for (int i = 0; i < 9; i++) begin
            if (pat[i]) hold[i] = prev_pat[i] ? hold[i] + 1 : 0;
            else        hold[i] = 0;
            expg[i] = pat[i] && (hold[i] >= DEAD);
        end
        prev_pat = pat;
        if (active)
            chk(gate == expg, "R4 R7", "gate pattern with dead time", gate, expg);
        else
            chk(gate == 9'd0, "R2", "gates off while disabled", gate, 0);
        chk(!(gate[0] && gate[1]) && !(gate[3] && (gate[2] || gate[4])) &&
            !(gate[5] && gate[6]) && !(gate[7] && gate[8]),
            "R6", "complementary overlap", gate, 0);
        if (active) begin
            chk(L >= -4 && L <= 4, "R3", "level range", L, 0);
            if (L > 0) chk(!(gate[6] || gate[7]), "R5", "positive bridge", gate, 0);
            if (L < 0) chk(!(gate[5] || gate[8]), "R5", "negative bridge", gate, 0);
            if (L >= -4 && L <= 4) seen[L + 4] = 1'b1;
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        for (int i = 0; i < 9; i++) hold[i] = 0;
        run(5);
        chk(gate == 9'd0 && lvl == 4'd0, "R1", "reset state", {lvl, gate}, 0);
        rst = 1'b0;
        run(20);
        chk(lvl == 4'd0, "R2", "idle level", lvl, 0);

        // Index 3.6, all carriers in phase: nine levels
        amp = 8'd58; en = 1'b1;
        run(40); seen = '0; run(RPER);
        chk(seen == 9'h1FF, "R8", "levels at index 3.6", seen, 9'h1FF);

        // Index 2.6: only -3..+3
        amp = 8'd42;
        run(RPER); seen = '0; run(RPER);
        chk(seen == 9'h0FE, "R8", "levels at index 2.6", seen, 9'h0FE);

        // Index 0: reference on the middle edge, level 0 only
        amp = 8'd0;
        run(20); seen = '0; run(RPER);
        chk(seen == 9'h010, "R8", "levels at index 0", seen, 9'h010);

        // Mirrored carriers above zero
        amp = 8'd58; mode = 2'd1;
        run(40); seen = '0; run(RPER);
        chk(seen == 9'h1FF, "R9", "levels in split mode", seen, 9'h1FF);

        // Alternately mirrored carriers
        mode = 2'd2;
        run(40); seen = '0; run(RPER);
        chk(seen == 9'h1FF, "R9", "levels in alternate mode", seen, 9'h1FF);

        // Clamped index
        amp = 8'd255; mode = 2'd0;
        run(40); seen = '0; run(RPER);
        chk(seen == 9'h1FF, "R8", "levels at clamped index", seen, 9'h1FF);

        // Disable mid-run, then restart through dead time
        en = 1'b0;
        run(30);
        chk(lvl == 4'd0, "R2", "level after disable", lvl, 0);
        en = 1'b1;
        run(60);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule